// File: doc/BRIEF.md
# Sign-Magnitude PWM Audio Driver

This block turns 8-bit voice samples into pulse trains on two speaker pins. Software writes a control register (start, carrier/sample-rate select, single-pin mode) and a sample register. While running, a 7-bit duty counter advances on an external carrier tick. The pin is high for the first M counts of each carrier period, where M is the sample magnitude. Each sample is replayed for a fixed number of carrier periods that depends on the rate, and then the next sample is taken.

In dual-pin (bridge) mode the top sample bit is a sign that steers the pulses to one pin while the other pin stays low. In single-pin mode the seven upper sample bits form the duty value on the first pin. A one-cycle strobe marks each new sample, so the writer can pace its data writes. Clearing the start bit lets the current carrier period finish before the block goes idle.

Top module: `pwm_voice_out`

## Requirements
- R1: After reset, and at any time before a start, `pwm_a`, `pwm_b` and `sample_strobe` are low. Writing sample data alone does not start output.
- R2: In dual-pin mode (control bit 3 = 0), a sample with bit 7 = 0 pulses `pwm_a` and holds `pwm_b` low. A sample with bit 7 = 1 pulses `pwm_b` and holds `pwm_a` low. The two pins are never high together.
- R3: In dual-pin mode the duty value M is sample bits 6..0. In each carrier period the active pin is high for exactly the first M counted ticks. A period lasts 128 ticks for rate codes 0 and 1 and 125 ticks for rate code 2. At rate code 2, values 125 to 127 keep the pin high for the whole period.
- R4: In single-pin mode (control bit 3 = 1), M is sample bits 7..1 on `pwm_a`, and `pwm_b` stays low.
- R5: The control register holds start in bit 0, the rate code in bits 2..1 and the mode in bit 3. Each sample lasts 6, 5 or 4 carrier periods for rate code 0, 1 or 2.
- R6: A control write that changes start from 0 to 1 restarts the counter at 0 on the next clock and latches the sample register as the current sample.
- R7: At each sample boundary the current sample reloads from the sample register if that register was written since the last latch. Otherwise the old sample repeats.
- R8: A control write that changes start from 1 to 0 lets output continue until the end of the carrier period in progress. After that, both pins are low and the counter is back at 0.
- R9: Rate code 3 forces both pins low and holds the duty counter, which resumes from where it was when a valid code is written.
- R10: `sample_strobe` is high for one clock, in the first cycle in which a new sample drives the pins. It is not raised at a start or at the end of a stop.
- R11: The duty counter advances only on clocks where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Carrier-count enable from the prescaler |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 4 | Control write value: bit0 start, bits2..1 rate, bit3 single-pin |
| data_we | input | 1 | Sample register write strobe |
| data_wdata | input | 8 | Sample write value |
| pwm_a | output | 1 | First speaker pin |
| pwm_b | output | 1 | Second speaker pin |
| sample_strobe | output | 1 | One-cycle pulse when a new sample begins |

## Verification
A wrong duty count shows up at the pins within one carrier period, as a high run of the wrong length or at the wrong place. A wrong sample-period count first appears at the next sample boundary, as a strobe arriving early or late. A stale or missed reload of the current sample shows up in the cycle after the boundary, as the wrong pin or the wrong duty. A stop that does not wait for the period to end is seen within the same period. The bench's behavioural model predicts every pin value on every clock, so any of these faults is flagged in the first cycle where it differs.

// File: rtl/pwm_voice_pkg.sv
// Shared constants, control-register layout and rate lookups for the
// PWM voice driver. Assumes an 8-bit sample whose top bit may be a sign.
package pwm_voice_pkg;

    parameter int SAMPLE_W = 8;
    parameter int CNT_W    = SAMPLE_W - 1;
    parameter int PER_W    = 3;

    typedef enum logic [1:0] {
        RATE_5K  = 2'd0,
        RATE_6K  = 2'd1,
        RATE_8K  = 2'd2,
        RATE_OFF = 2'd3
    } rate_e;

    // Field order fixes the write layout: single is bit 3, rate is bits 2..1, start is bit 0.
    typedef struct packed {
        logic  single;
        rate_e rate;
        logic  start;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // Highest duty count of a carrier period for a rate.
    function automatic logic [CNT_W-1:0] last_count(input rate_e r);
        return (r == RATE_8K) ? CNT_W'(124) : CNT_W'(127);
    endfunction

    // Carrier periods per sample for a rate (0 when output is disabled).
    function automatic logic [PER_W-1:0] periods(input rate_e r);
        case (r)
            RATE_5K: return PER_W'(6);
            RATE_6K: return PER_W'(5);
            RATE_8K: return PER_W'(4);
            default: return PER_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/pwm_voice_regs.sv
// Control and sample registers. Detects start and stop edges on control
// writes, tracks whether the sample register holds unplayed data, and keeps
// the sample currently driving the pins.
// Assumes the timebase asserts load_sample only at a sample boundary.
module pwm_voice_regs
    import pwm_voice_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_we,
    input  logic [CTL_W-1:0]    ctl_wdata,
    input  logic                data_we,
    input  logic [SAMPLE_W-1:0] data_wdata,
    input  logic                load_sample,
    output ctl_t                ctl_q,
    output logic                start_pulse,
    output logic                stop_req,
    output logic [SAMPLE_W-1:0] cur_q
);

    ctl_t                ctl_new;
    logic [SAMPLE_W-1:0] data_q;
    logic                fresh_q;

    // Edge detection of the start bit on a control write.
    always_comb begin
        ctl_new     = ctl_t'(ctl_wdata);
        start_pulse = ctl_we &  ctl_new.start & ~ctl_q.start;
        stop_req    = ctl_we & ~ctl_new.start &  ctl_q.start;
    end

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '{single: 1'b0, rate: RATE_5K, start: 1'b0};
        else if (ctl_we) ctl_q <= ctl_new;
    end

    // Sample register and its unplayed-data flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            fresh_q <= 1'b0;
        end else begin
            if (data_we)                         fresh_q <= 1'b1;
            else if (start_pulse || load_sample) fresh_q <= 1'b0;
            if (data_we) data_q <= data_wdata;
        end
    end

    // Current sample: latched at start, reloaded at a boundary only if fresh.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cur_q <= '0;
        else if (start_pulse)              cur_q <= data_q;
        else if (load_sample && fresh_q)   cur_q <= data_q;
    end

    AST_FRESH_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        data_we |=> fresh_q); // R7
    AST_START_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> (cur_q == $past(data_q))); // R6

endmodule

// File: rtl/pwm_voice_timebase.sv
// Duty counter, carrier-period counter and run/stop sequencing. The duty
// counter steps on tick while running with a valid rate. Stop requests are
// deferred to the end of the carrier period in progress.
// Assumes start_pulse and stop_req are never high together.
module pwm_voice_timebase
    import pwm_voice_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  rate_e            rate,
    input  logic             start_pulse,
    input  logic             stop_req,
    output logic             run_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             load_sample,
    output logic             strobe_q
);

    logic             stopping_q;
    logic [PER_W-1:0] per_q;
    logic             rate_ok, period_end, sample_end;

    // Period and sample boundary decode.
    always_comb begin
        rate_ok     = (rate != RATE_OFF);
        period_end  = run_q & rate_ok & tick & (cnt_q >= last_count(rate));
        sample_end  = period_end & (per_q >= periods(rate) - PER_W'(1));
        load_sample = sample_end & ~stopping_q;
    end

    // Run state, duty counter and period-in-sample counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q      <= 1'b0;
            stopping_q <= 1'b0;
            cnt_q      <= '0;
            per_q      <= '0;
        end else if (start_pulse) begin
            run_q      <= 1'b1;
            stopping_q <= 1'b0;
            cnt_q      <= '0;
            per_q      <= '0;
        end else begin
            if (stop_req && run_q) stopping_q <= 1'b1;
            if (period_end) begin
                cnt_q <= '0;
                if (stopping_q) begin
                    run_q      <= 1'b0;
                    stopping_q <= 1'b0;
                    per_q      <= '0;
                end else begin
                    per_q <= sample_end ? '0 : per_q + 1'b1;
                end
            end else if (run_q && rate_ok && tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Strobe in the first cycle a newly loaded sample drives the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= load_sample & ~start_pulse;
    end

    AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (cnt_q == '0 && per_q == '0)); // R8
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !start_pulse) |=> $stable(cnt_q)); // R11
    AST_PER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (per_q < PER_W'(6))); // R5
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_q |=> !strobe_q); // R10

endmodule

// File: rtl/pwm_voice_steer.sv
// Duty comparison and sign steering onto the two speaker pins.
// Assumes cnt and cur come from registers, so the pins change only at clock edges.
module pwm_voice_steer
    import pwm_voice_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run,
    input  rate_e               rate,
    input  logic                single,
    input  logic [SAMPLE_W-1:0] cur,
    input  logic [CNT_W-1:0]    cnt,
    output logic                pwm_a,
    output logic                pwm_b
);

    logic [CNT_W-1:0] mag;
    logic             sign, high;

    // Magnitude select, duty compare and pin steering.
    always_comb begin
        mag   = single ? cur[SAMPLE_W-1:1] : cur[CNT_W-1:0];
        sign  = cur[SAMPLE_W-1] & ~single;
        high  = run & (rate != RATE_OFF) & (cnt < mag);
        pwm_a = high & ~sign;
        pwm_b = high &  sign;
    end

    AST_PINS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(pwm_a && pwm_b)); // R2
    AST_RATE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rate == RATE_OFF) |-> (!pwm_a && !pwm_b)); // R9

endmodule

// File: rtl/pwm_voice_out.sv
// Top of the PWM voice driver: registers, timebase and pin steering.
// Assumes tick is a one-clock enable from an external prescaler.
module pwm_voice_out
    import pwm_voice_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                ctl_we,
    input  logic [CTL_W-1:0]    ctl_wdata,
    input  logic                data_we,
    input  logic [SAMPLE_W-1:0] data_wdata,
    output logic                pwm_a,
    output logic                pwm_b,
    output logic                sample_strobe
);

    ctl_t                ctl_q;
    logic                start_pulse, stop_req, load_sample, run_q;
    logic [SAMPLE_W-1:0] cur_q;
    logic [CNT_W-1:0]    cnt_q;

    pwm_voice_regs i_regs (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .data_we(data_we), .data_wdata(data_wdata),
        .load_sample(load_sample),
        .ctl_q(ctl_q), .start_pulse(start_pulse), .stop_req(stop_req),
        .cur_q(cur_q)
    );

    pwm_voice_timebase i_timebase (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rate(ctl_q.rate),
        .start_pulse(start_pulse), .stop_req(stop_req),
        .run_q(run_q), .cnt_q(cnt_q), .load_sample(load_sample),
        .strobe_q(sample_strobe)
    );

    pwm_voice_steer i_steer (
        .clk(clk), .rst_n(rst_n), .run(run_q), .rate(ctl_q.rate),
        .single(ctl_q.single), .cur(cur_q), .cnt(cnt_q),
        .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

endmodule

// File: tb/test_pwm_voice_out.sv
`timescale 1ns/1ps
module test_pwm_voice_out;

    logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic       ctl_we = 1'b0, data_we = 1'b0;
    logic [3:0] ctl_wdata = '0;
    logic [7:0] data_wdata = '0;
    logic       pwm_a, pwm_b, sample_strobe;

    int checks = 0, fails = 0, cyc = 0;
    bit tick_every = 1'b1, model_on = 1'b0;

    // behavioural model state
    int m_run, m_stop, m_cnt, m_per, m_cur, m_data, m_fresh;
    int m_start, m_rate, m_single, m_strobe;
    int sp, sr, rok, lastc, np, pe, se, ld, nf, nstop;

    always #2 clk = ~clk;

    pwm_voice_out i_pwm_voice_out (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .data_we(data_we), .data_wdata(data_wdata),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .sample_strobe(sample_strobe)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_stop = 0; m_cnt = 0; m_per = 0; m_cur = 0; m_data = 0;
            m_fresh = 0; m_start = 0; m_rate = 0; m_single = 0; m_strobe = 0;
        end else begin
            sp    = (ctl_we && ctl_wdata[0] && m_start == 0) ? 1 : 0;
            sr    = (ctl_we && !ctl_wdata[0] && m_start == 1) ? 1 : 0;
            rok   = (m_rate != 3) ? 1 : 0;
            lastc = (m_rate == 2) ? 124 : 127;
            np    = (m_rate == 0) ? 6 : (m_rate == 1) ? 5 : 4;
            pe    = (m_run != 0 && rok != 0 && tick && m_cnt >= lastc) ? 1 : 0;
            se    = (pe != 0 && m_per >= np - 1) ? 1 : 0;
            ld    = (se != 0 && m_stop == 0) ? 1 : 0;
            m_strobe = (ld != 0 && sp == 0) ? 1 : 0;
            if (sp != 0) m_cur = m_data;
            else if (ld != 0 && m_fresh != 0) m_cur = m_data;
            nf = data_we ? 1 : ((sp != 0 || ld != 0) ? 0 : m_fresh);
            if (sp != 0) begin
                m_run = 1; m_stop = 0; m_cnt = 0; m_per = 0;
            end else begin
                nstop = m_stop;
                if (sr != 0 && m_run != 0) nstop = 1;
                if (pe != 0) begin
                    m_cnt = 0;
                    if (m_stop != 0) begin m_run = 0; nstop = 0; m_per = 0; end
                    else m_per = (se != 0) ? 0 : m_per + 1;
                end else if (m_run != 0 && rok != 0 && tick) begin
                    m_cnt = m_cnt + 1;
                end
                m_stop = nstop;
            end
            m_fresh = nf;
            if (data_we) m_data = data_wdata;
            if (ctl_we) begin
                m_start = ctl_wdata[0]; m_rate = ctl_wdata[2:1]; m_single = ctl_wdata[3];
            end
        end
    end

    // per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && model_on) begin
            int mag, hi, ea, eb;
            mag = (m_single != 0) ? (m_cur >> 1) : (m_cur & 127);
            hi  = (m_run != 0 && m_rate != 3 && m_cnt < mag) ? 1 : 0;
            ea  = (hi != 0 && (m_single != 0 || m_cur < 128)) ? 1 : 0;
            eb  = (hi != 0 && m_single == 0 && m_cur >= 128) ? 1 : 0;
            check(pwm_a == ea, (m_single != 0) ? "R4" : "R3", "pwm_a per cycle", pwm_a, ea);
            check(pwm_b == eb, "R2", "pwm_b per cycle", pwm_b, eb);
            check(sample_strobe == m_strobe, "R10", "strobe per cycle", sample_strobe, m_strobe);
        end
    end

    // carrier tick: every cycle, or every other cycle
    always @(negedge clk) begin
        if (tick_every) tick <= 1'b1;
        else            tick <= ~tick;
    end

    task automatic wr_ctl(input bit st, input int rate, input bit single);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = {single, rate[1:0], st};
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] v);
        @(negedge clk);
        data_we = 1'b1; data_wdata = v;
        @(negedge clk);
        data_we = 1'b0;
    endtask

    task automatic window(input int n, output int a, output int b, output int s);
        a = 0; b = 0; s = 0;
        for (int i = 0; i < n; i++) begin
            a += pwm_a; b += pwm_b; s += sample_strobe;
            @(negedge clk);
        end
    endtask

    task automatic wait_strobe(output int n);
        n = 0;
        while (!sample_strobe && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int a, b, s, n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        model_on = 1'b1;
        @(negedge clk);
        check(!pwm_a && !pwm_b && !sample_strobe, "R1", "idle after reset",
              {pwm_a, pwm_b, sample_strobe}, 0);
        wr_data(8'h40);
        window(50, a, b, s);
        check(a + b + s == 0, "R1", "no output without start", a + b + s, 0);

        // dual mode, rate 0, positive sample of 32
        wr_data(8'h20);
        wr_ctl(1'b1, 0, 1'b0);
        window(128, a, b, s);
        check(a == 32, "R6", "first period uses latched sample", a, 32);
        check(b == 0, "R2", "pwm_b low for positive sample", b, 0);

        // negative sample takes over at the next boundary
        wr_data(8'h85);
        wait_strobe(n);
        window(128, a, b, s);
        check(b == 5, "R2", "negative sample pulses pwm_b", b, 5);
        check(a == 0, "R2", "pwm_a low for negative sample", a, 0);
        wait_strobe(n);
        check(128 + n == 768, "R5", "rate 0 sample length", 128 + n, 768);
        window(128, a, b, s);
        check(b == 5, "R7", "unwritten sample repeats", b, 5);

        // rate 1
        wr_ctl(1'b1, 1, 1'b0);
        wait_strobe(n);
        window(128, a, b, s);
        wait_strobe(n);
        check(128 + n == 640, "R5", "rate 1 sample length", 128 + n, 640);

        // rate 2 with full-scale code
        wr_data(8'h7F);
        wr_ctl(1'b1, 2, 1'b0);
        wait_strobe(n);
        window(125, a, b, s);
        check(a == 125, "R3", "rate 2 code 127 high all period", a, 125);
        wait_strobe(n);
        check(125 + n == 500, "R5", "rate 2 sample length", 125 + n, 500);

        // single-pin mode
        wr_data(8'h85);
        wr_ctl(1'b1, 0, 1'b1);
        wait_strobe(n);
        window(128, a, b, s);
        check(a == 66, "R4", "single mode duty from bits 7..1", a, 66);
        check(b == 0, "R4", "single mode pwm_b low", b, 0);

        // stop waits for the period end
        wr_data(8'hFF);
        wait_strobe(n);
        window(10, a, b, s);
        wr_ctl(1'b0, 0, 1'b1);
        window(100, a, b, s);
        check(a == 100, "R8", "output continues after stop write", a, 100);
        window(40, a, b, s);
        window(300, a, b, s);
        check(a + b + s == 0, "R8", "quiet after stop", a + b + s, 0);

        // disabled rate code holds counter
        wr_ctl(1'b1, 3, 1'b0);
        window(300, a, b, s);
        check(a + b == 0, "R9", "rate 3 pins low", a + b, 0);
        wr_ctl(1'b1, 0, 1'b0);
        window(128, a, b, s);
        check(b == 127, "R9", "counter resumes from zero", b, 127);

        // tick every other cycle doubles the sample length
        tick_every = 1'b0;
        wait_strobe(n);
        @(negedge clk);
        wait_strobe(n);
        wait_strobe(n);
        @(negedge clk);
        wait_strobe(n);
        check(n + 1 == 1536, "R11", "half-rate tick sample length", n + 1, 1536);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule